// File: doc/BRIEF.md
# DMA channel request arbiter

This block sits in front of a multi-channel DMA transfer engine and decides which channel runs next. Every channel, 16 by default, can ask for service in two ways. Software raises a start flag held in that channel's transfer descriptor. A peripheral raises a hardware request line. The peripheral lines pass through an input register before they can compete. Each one also counts only while the matching bit of a hardware-enable register is set. Each channel carries a programmable priority level. The highest level wins, and on a tie the higher channel number wins.

The chosen channel is registered in a candidate stage and then launched. The engine sees a one-cycle `launch` pulse with the channel number on `launch_ch`. In the same cycle, `sw_clr` gives a one-hot strobe that the descriptor store uses to clear that channel's start flag. While a channel runs, the candidate stage keeps looking for the next winner and leaves out the running channel. A done indication therefore launches the next channel on the following cycle. If the engine instead reports a channel link or a scatter-gather reload, the launch state machine waits two extra cycles. This gives the linked or reloaded channel time to join the pool before the choice is made.

The launch state machine has four states. IDLE means no channel is running. RUN means a channel was launched and is executing. HOLD1 and HOLD2 are the two wait cycles after a link or reload. Its transitions are:
- IDLE→RUN on a valid candidate (launch).
- RUN→RUN on done with a valid candidate (back-to-back launch).
- RUN→IDLE on done with no candidate.
- RUN→HOLD1 on link or reload. This transition has precedence over done.
- HOLD1→HOLD2 unconditionally.
- HOLD2→RUN on a valid candidate (launch).
- HOLD2→IDLE otherwise.

Top module: `dma_req_arbiter`

## Requirements
- R1: A synchronous active-high reset leaves `launch` and `sw_clr` low and every hardware-enable bit zero. It sets each channel's priority level to its own channel number, so with all 16 start flags raised the channels launch in the order 15, 14, …, 0.
- R2: From IDLE, a start flag first sampled high at clock edge k gives `launch` high after edge k+1. In that same cycle `launch_ch` equals the channel, and `sw_clr` has only the bit at position equal to the channel number set.
- R3: From IDLE, an enabled hardware request first sampled high at edge k gives `launch` high after edge k+2. This is one cycle later than a start flag.
- R4: A hardware request whose enable bit is 0 never causes a launch. Writing `hwen_val` with `hwen_we` high replaces the whole enable vector at the next edge.
- R5: Among eligible channels, the channel with the numerically highest priority level is launched.
- R6: Among eligible channels with equal priority levels, the higher channel number is launched.
- R7: With `pri_we` high at an edge, channel `pri_ch` takes `pri_val` as its priority level. The other channels keep their levels.
- R8: `launch` is one cycle wide. No further launch occurs while a channel runs until `eng_done` or `eng_link` is sampled.
- R9: When `eng_done` is sampled at edge D in RUN and another channel is eligible, the next launch is high after edge D, with no arbitration gap.
- R10: When `eng_link` is sampled at edge D in RUN, `launch` stays low after edges D and D+1 and can rise after edge D+2. A request first raised after edge D takes part in that selection.
- R11: The running channel is excluded from selection even while its request stays raised.
- R12: When `eng_done` is sampled with nothing eligible, the block returns to IDLE and `launch` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | NCH | Start flag per channel, read from the descriptors |
| hw_req | input | NCH | Peripheral request line per channel (level) |
| hwen_we | input | 1 | Write strobe for the hardware-enable vector |
| hwen_val | input | NCH | New hardware-enable vector |
| pri_we | input | 1 | Write strobe for one channel's priority level |
| pri_ch | input | $clog2(NCH) | Channel whose priority is written |
| pri_val | input | PRI_W | Priority level written |
| eng_done | input | 1 | Engine reports the running channel finished |
| eng_link | input | 1 | Engine reports a channel link or scatter-gather reload on finish |
| launch | output | 1 | One-cycle pulse starting the selected channel |
| launch_ch | output | $clog2(NCH) | Selected channel number, held while it runs |
| sw_clr | output | NCH | One-hot strobe clearing the launched channel's start flag |

## Verification
The latency patterns drive each of the 16 channels alone, first by start flag and then by hardware request. These tell the direct software path apart from the registered peripheral path. A sweep over every ordered pair of channels, under priorities rewritten to a scrambled permutation, separates level-based choice from number-based choice and from the reset order. An equal-level set exercises the tie rule. A request raised just after a link event distinguishes the two-cycle hold from an immediate relaunch. A still-raised request from the running channel shows that the channel is excluded. A disabled hardware request, and a done with nothing pending, show that no spurious launch occurs.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD1 = 2'd2,
        ST_HOLD2 = 2'd3
    } arb_state_e;

endpackage

// File: rtl/dma_req_collect.sv
module dma_req_collect #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] sw_start,
    input  logic [NCH-1:0] hw_req,
    input  logic           hwen_we,
    input  logic [NCH-1:0] hwen_val,
    output logic [NCH-1:0] elig
);

    logic [NCH-1:0] hw_q;
    logic [NCH-1:0] en_q;

    // Peripheral lines are registered once; start flags are used as they stand.
    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q <= '0;
            en_q <= '0;
        end else begin
            hw_q <= hw_req;
            if (hwen_we) begin
                en_q <= hwen_val;
            end
        end
    end

    always_comb begin
        elig = sw_start | (hw_q & en_q);
    end

endmodule

// File: rtl/dma_prio_select.sv
module dma_prio_select #(
    parameter int NCH   = 16,
    parameter int PRI_W = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   elig,
    input  logic [NCH-1:0]   excl,
    input  logic             pri_we,
    input  logic [CH_W-1:0]  pri_ch,
    input  logic [PRI_W-1:0] pri_val,
    output logic             cand_v,
    output logic [CH_W-1:0]  cand_ch
);

    logic [PRI_W-1:0] pri_q [NCH];
    logic [NCH-1:0]   masked;
    logic             win_v;
    logic [CH_W-1:0]  win_ch;
    logic [PRI_W-1:0] win_pri;
    logic [PRI_W-1:0] cand_pri;

    always_comb begin
        masked = elig & ~excl;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_pri
            always_ff @(posedge clk) begin
                if (rst) begin
                    pri_q[g] <= PRI_W'(g);
                end else if (pri_we && (pri_ch == CH_W'(g))) begin
                    pri_q[g] <= pri_val;
                end
            end

            // R5: no eligible channel outranked the registered winner
            assert_no_stronger_R5: assert property (@(posedge clk) disable iff (rst)
                (cand_v && $past(masked[g])) |-> ($past(pri_q[g]) <= cand_pri));

            // R6: on equal level the winner has the higher channel number
            assert_tie_high_R6: assert property (@(posedge clk) disable iff (rst)
                (cand_v && $past(masked[g]) && ($past(pri_q[g]) == cand_pri))
                |-> (CH_W'(g) <= cand_ch));
        end
    endgenerate

    // Ascending scan with >= lets a later (higher) channel take equal levels.
    always_comb begin
        win_v   = 1'b0;
        win_ch  = '0;
        win_pri = '0;
        for (int i = 0; i < NCH; i++) begin
            if (masked[i] && (!win_v || (pri_q[i] >= win_pri))) begin
                win_v   = 1'b1;
                win_ch  = CH_W'(i);
                win_pri = pri_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_v   <= 1'b0;
            cand_ch  <= '0;
            cand_pri <= '0;
        end else begin
            cand_v   <= win_v;
            cand_ch  <= win_ch;
            cand_pri <= win_pri;
        end
    end

endmodule

// File: rtl/dma_launch_fsm.sv
module dma_launch_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cand_v,
    input  logic [CH_W-1:0] cand_ch,
    input  logic            eng_done,
    input  logic            eng_link,
    output logic            launch,
    output logic [CH_W-1:0] launch_ch,
    output logic [NCH-1:0]  sw_clr,
    output logic [NCH-1:0]  excl
);

    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    arb_state_e st, nxt;
    logic       fire;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt  = st;
        fire = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (cand_v) begin
                    fire = 1'b1;
                    nxt  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (eng_link) begin
                    nxt = ST_HOLD1;
                end else if (eng_done) begin
                    fire = cand_v;
                    nxt  = cand_v ? ST_RUN : ST_IDLE;
                end
            end
            ST_HOLD1: begin
                nxt = ST_HOLD2;
            end
            ST_HOLD2: begin
                fire = cand_v;
                nxt  = cand_v ? ST_RUN : ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // Keep the running and the launching channel out of the next candidate.
    always_comb begin
        excl = '0;
        if (st == ST_RUN) begin
            excl = excl | (ONE << launch_ch);
        end
        if (fire) begin
            excl = excl | (ONE << cand_ch);
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            launch    <= 1'b0;
            launch_ch <= '0;
            sw_clr    <= '0;
        end else begin
            launch <= fire;
            sw_clr <= fire ? (ONE << cand_ch) : '0;
            if (fire) begin
                launch_ch <= cand_ch;
            end
        end
    end

    // R8: a launch out of RUN needs a done indication
    assert_launch_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (launch && ($past(st) == ST_RUN)) |-> $past(eng_done));

    // R10: two quiet cycles after a link or reload
    assert_link_hold_R10: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_RUN) && eng_link) |=> (!launch ##1 !launch));

    // R11: back-to-back launch never repeats the channel that just finished
    assert_not_same_R11: assert property (@(posedge clk) disable iff (rst)
        (launch && ($past(st) == ST_RUN)) |-> (launch_ch != $past(launch_ch)));

    // R2: the clear strobe accompanies exactly the launch
    assert_clr_with_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (launch == (sw_clr != '0)) && $onehot0(sw_clr));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NCH   = 16,
    parameter int PRI_W = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   sw_start,
    input  logic [NCH-1:0]   hw_req,
    input  logic             hwen_we,
    input  logic [NCH-1:0]   hwen_val,
    input  logic             pri_we,
    input  logic [CH_W-1:0]  pri_ch,
    input  logic [PRI_W-1:0] pri_val,
    input  logic             eng_done,
    input  logic             eng_link,
    output logic             launch,
    output logic [CH_W-1:0]  launch_ch,
    output logic [NCH-1:0]   sw_clr
);

    logic [NCH-1:0]  elig;
    logic [NCH-1:0]  excl;
    logic            cand_v;
    logic [CH_W-1:0] cand_ch;

    dma_req_collect #(.NCH(NCH)) u_collect (
        .clk      (clk),
        .rst      (rst),
        .sw_start (sw_start),
        .hw_req   (hw_req),
        .hwen_we  (hwen_we),
        .hwen_val (hwen_val),
        .elig     (elig)
    );

    dma_prio_select #(.NCH(NCH), .PRI_W(PRI_W)) u_select (
        .clk     (clk),
        .rst     (rst),
        .elig    (elig),
        .excl    (excl),
        .pri_we  (pri_we),
        .pri_ch  (pri_ch),
        .pri_val (pri_val),
        .cand_v  (cand_v),
        .cand_ch (cand_ch)
    );

    dma_launch_fsm #(.NCH(NCH)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cand_v    (cand_v),
        .cand_ch   (cand_ch),
        .eng_done  (eng_done),
        .eng_link  (eng_link),
        .launch    (launch),
        .launch_ch (launch_ch),
        .sw_clr    (sw_clr),
        .excl      (excl)
    );

endmodule

// File: tb/dma_req_arbiter_bench.sv
`timescale 1ns/1ps
module dma_req_arbiter_bench;

    localparam int NCH = 16;
    localparam int CW  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCH-1:0]  sw_start = '0;
    logic [NCH-1:0]  hw_req = '0;
    logic            hwen_we = 1'b0;
    logic [NCH-1:0]  hwen_val = '0;
    logic            pri_we = 1'b0;
    logic [CW-1:0]   pri_ch = '0;
    logic [3:0]      pri_val = '0;
    logic            eng_done = 1'b0;
    logic            eng_link = 1'b0;
    logic            launch;
    logic [CW-1:0]   launch_ch;
    logic [NCH-1:0]  sw_clr;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_req_arbiter #(.NCH(NCH), .PRI_W(4)) u_dma_req_arbiter (
        .clk(clk), .rst(rst), .sw_start(sw_start), .hw_req(hw_req),
        .hwen_we(hwen_we), .hwen_val(hwen_val), .pri_we(pri_we),
        .pri_ch(pri_ch), .pri_val(pri_val), .eng_done(eng_done),
        .eng_link(eng_link), .launch(launch), .launch_ch(launch_ch),
        .sw_clr(sw_clr)
    );

    function automatic int prio_of(input int c);
        return (c * 5 + 3) % 16;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_launch(output int n);
        n = 0;
        do begin
            cyc();
            n++;
        end while (!launch && n < 20);
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        cyc();
        eng_done = 1'b0;
    endtask

    task automatic write_pri(input int c, input int v);
        pri_we  = 1'b1;
        pri_ch  = CW'(c);
        pri_val = 4'(v);
        cyc();
        pri_we  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1: reset state
        chk(launch == 1'b0, "R1 launch", int'(launch), 0);
        chk(sw_clr == '0, "R1 sw_clr", int'(sw_clr), 0);

        // R1, R9, R12: reset priorities give descending order, back to back
        sw_start = '1;
        wait_launch(n);
        chk(n == 2, "R2 latency all", n, 2);
        chk(launch && launch_ch == 4'd15, "R1 first", int'(launch_ch), 15);
        for (int k = 14; k >= 0; k--) begin
            sw_start[k + 1] = 1'b0;
            done_pulse();
            chk(launch && launch_ch == CW'(k), "R1 R9 order", int'(launch_ch), k);
        end
        sw_start[0] = 1'b0;
        done_pulse();
        chk(launch == 1'b0, "R12 idle", int'(launch), 0);
        cyc();
        chk(launch == 1'b0, "R12 idle2", int'(launch), 0);

        // R2: software latency on every channel
        for (int c = 0; c < NCH; c++) begin
            sw_start[c] = 1'b1;
            wait_launch(n);
            chk(n == 2, "R2 latency", n, 2);
            chk(launch_ch == CW'(c), "R2 channel", int'(launch_ch), c);
            chk(sw_clr == (NCH'(1) << c), "R2 clear", int'(sw_clr), 1 << c);
            sw_start[c] = 1'b0;
            done_pulse();
            chk(launch == 1'b0, "R8 width", int'(launch), 0);
            cyc();
        end

        // R4: disabled hardware requests are ignored
        hw_req = '1;
        repeat (6) begin
            cyc();
            chk(launch == 1'b0, "R4 disabled", int'(launch), 0);
        end
        hwen_we = 1'b1;
        hwen_val = NCH'(1) << 5;
        wait_launch(n);
        hwen_we = 1'b0;
        chk(n == 3 && launch_ch == 4'd5, "R4 enabled", int'(launch_ch), 5);
        hw_req = '0;
        done_pulse();
        cyc();
        cyc();
        chk(launch == 1'b0, "R4 quiet", int'(launch), 0);

        // R3: hardware latency on every channel
        hwen_we = 1'b1;
        hwen_val = '1;
        cyc();
        hwen_we = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            hw_req[c] = 1'b1;
            wait_launch(n);
            chk(n == 3, "R3 latency", n, 3);
            chk(launch_ch == CW'(c), "R3 channel", int'(launch_ch), c);
            hw_req[c] = 1'b0;
            done_pulse();
            cyc();
            cyc();
        end

        // R5, R7: scrambled priorities, every ordered pair
        for (int c = 0; c < NCH; c++) write_pri(c, prio_of(c));
        for (int a = 0; a < NCH; a++) begin
            for (int b = 0; b < NCH; b++) begin
                if (a != b) begin
                    int w;
                    int o;
                    w = (prio_of(a) > prio_of(b)) ? a : b;
                    o = (w == a) ? b : a;
                    sw_start = (NCH'(1) << a) | (NCH'(1) << b);
                    wait_launch(n);
                    chk(n == 2 && launch_ch == CW'(w), "R5 R7 winner", int'(launch_ch), w);
                    sw_start[w] = 1'b0;
                    done_pulse();
                    chk(launch && launch_ch == CW'(o), "R9 second", int'(launch_ch), o);
                    sw_start[o] = 1'b0;
                    done_pulse();
                    cyc();
                end
            end
        end

        // R6: equal levels resolve to the higher channel
        for (int c = 0; c < NCH; c++) write_pri(c, 0);
        sw_start = (NCH'(1) << 3) | (NCH'(1) << 9) | (NCH'(1) << 12);
        wait_launch(n);
        chk(launch_ch == 4'd12, "R6 tie first", int'(launch_ch), 12);
        sw_start[12] = 1'b0;
        done_pulse();
        chk(launch && launch_ch == 4'd9, "R6 tie second", int'(launch_ch), 9);
        sw_start[9] = 1'b0;
        done_pulse();
        chk(launch && launch_ch == 4'd3, "R6 tie third", int'(launch_ch), 3);
        sw_start[3] = 1'b0;
        done_pulse();
        cyc();

        // R10: link holds two cycles, late request joins the choice
        sw_start = (NCH'(1) << 10) | (NCH'(1) << 4);
        wait_launch(n);
        chk(launch_ch == 4'd10, "R10 setup", int'(launch_ch), 10);
        sw_start[10] = 1'b0;
        eng_link = 1'b1;
        cyc();
        chk(launch == 1'b0, "R10 hold1", int'(launch), 0);
        eng_link = 1'b0;
        sw_start[7] = 1'b1;
        cyc();
        chk(launch == 1'b0, "R10 hold2", int'(launch), 0);
        cyc();
        chk(launch && launch_ch == 4'd7, "R10 linked", int'(launch_ch), 7);
        sw_start[7] = 1'b0;
        done_pulse();
        chk(launch && launch_ch == 4'd4, "R9 after link", int'(launch_ch), 4);
        sw_start[4] = 1'b0;
        done_pulse();
        cyc();

        // R8, R11: running channel keeps its request, no relaunch
        sw_start = (NCH'(1) << 6) | (NCH'(1) << 1);
        wait_launch(n);
        chk(launch_ch == 4'd6, "R11 setup", int'(launch_ch), 6);
        repeat (5) begin
            cyc();
            chk(launch == 1'b0, "R8 no launch while running", int'(launch), 0);
        end
        done_pulse();
        chk(launch && launch_ch == 4'd1, "R11 excluded", int'(launch_ch), 1);
        sw_start = '0;
        done_pulse();
        cyc();
        chk(launch == 1'b0, "R12 final idle", int'(launch), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule